// File: doc/BRIEF.md
# Sign-Controlled Windowed Cross-Correlator

This block keeps a running cross-correlation matrix between a vector of antipodal decision bits and a vector of signed 8-bit received samples. The matrix is taken over a sliding window of the most recent bit/sample vector pairs. Each bit picks whether its sample is added or subtracted, so no multiplier is needed. Every matrix entry is a 16-bit two's-complement word. Each row of the matrix lives in its own single-port RAM bank, and all rows are updated in parallel, one sample column at a time.

The caller pulses a start strobe with four operands: the new bit vector, the new sample vector, and the bit and sample vectors that are leaving the window. While the block is busy it walks the columns. For each column it reads every row bank, adds the new term, removes the outgoing term, and writes the result back. A clear command zeroes the whole matrix and re-arms the window-fill counter. Until the window has filled, the outgoing operands are not used. Any entry can be read through a random-access port while the block is idle. A complex estimator uses two instances, one on the real parts and one on the imaginary parts of the samples.

Top module: `sign_xcorr`

## Requirements
- R1: While reset is asserted, and after it is released, `busy_o` and `rd_valid_o` are 0 until a command arrives.
- R2: `clr_i` accepted while idle sets every matrix entry to 0. `busy_o` then stays high for exactly COLS cycles.
- R3: An accepted update adds a term to entry (row i, column j). The term is +s when bit i of `bit_new_i` is 1 and -s when it is 0. Here s is the signed byte `samp_new_i[j*8 +: 8]`.
- R4: Once WIN updates have completed since the last clear, each update also subtracts the term built from `bit_old_i` and `samp_old_i`, using the same encoding as R3. Before that point the outgoing operands have no effect.
- R5: After `start_i` is accepted while idle, `busy_o` is high for exactly 4*COLS cycles, starting with the next cycle.
- R6: `start_i` and `clr_i` have no effect while `busy_o` is high. Neither the busy span nor the matrix contents change.
- R7: The operands are sampled only in the cycle `start_i` is accepted. Changing them while busy has no effect on the result.
- R8: A `rd_req_i` while idle, with no command in the same cycle, raises `rd_valid_o` in the next cycle. `rd_data_o` then carries entry (`rd_row_i`, `rd_col_i`) as a 16-bit two's-complement value.
- R9: A `rd_req_i` while busy is ignored, and `rd_valid_o` stays 0 in the next cycle.
- R10: When `clr_i` and `start_i` arrive together while idle, only the clear runs.
- R11: Entries are 16-bit two's-complement. No add or subtract step overflows while the window span stays within that range.
- R12: A clear re-arms fill counting. The outgoing operands are ignored again for the next WIN updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Zero the matrix and re-arm the window |
| start_i | input | 1 | Begin one windowed update |
| bit_new_i | input | ROWS | Incoming bits, 1 means +1 |
| samp_new_i | input | COLS*8 | Incoming samples, column j at bits j*8+7..j*8 |
| bit_old_i | input | ROWS | Bits leaving the window |
| samp_old_i | input | COLS*8 | Samples leaving the window |
| busy_o | output | 1 | Clear or update in progress |
| rd_req_i | input | 1 | Read request |
| rd_row_i | input | $clog2(ROWS) | Read row index |
| rd_col_i | input | $clog2(COLS) | Read column index |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 16 | Entry value |

## Verification
The overflow assertions assume three things about the caller. First, the outgoing operands are exactly the pair accepted WIN updates earlier. Second, WIN+1 full-scale samples fit in 16 bits. Third, a clear comes before the first update, so the RAM holds no undefined words. The bench meets all three. It keeps a ring of the last WIN pairs and replays the oldest as the outgoing operands once the window is full. It feeds random garbage as outgoing operands only while subtraction must be suppressed. It also clears right after reset and again before the re-arm phase.

// File: rtl/sxc_pkg.sv
package sxc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CLR  = 3'd1,
    ST_RD   = 3'd2,
    ST_ADD  = 3'd3,
    ST_SUB  = 3'd4,
    ST_WR   = 3'd5
  } sxc_state_e;
endpackage

// File: rtl/sxc_ctrl.sv
module sxc_ctrl
  import sxc_pkg::*;
#(
  parameter int COLS = 6,
  parameter int WIN  = 3,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int FW  = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          start_i,
  output sxc_state_e    st_o,
  output logic [CW-1:0] col_o,
  output logic          sub_en_o
);

  sxc_state_e    st_q, st_n;
  logic [CW-1:0] col_q, col_n;
  logic [FW-1:0] fill_q, fill_n;
  logic          last_col;

  assign last_col = (col_q == CW'(COLS - 1));

  always_comb begin
    st_n   = st_q;
    col_n  = col_q;
    fill_n = fill_q;
    unique case (st_q)
      ST_IDLE: begin
        if (clr_i) begin
          st_n   = ST_CLR;
          col_n  = '0;
          fill_n = '0;
        end else if (start_i) begin
          st_n  = ST_RD;
          col_n = '0;
        end
      end
      ST_CLR: begin
        if (last_col) st_n = ST_IDLE;
        else          col_n = col_q + CW'(1);
      end
      ST_RD:  st_n = ST_ADD;
      ST_ADD: st_n = ST_SUB;
      ST_SUB: st_n = ST_WR;
      ST_WR: begin
        if (last_col) begin
          st_n = ST_IDLE;
          if (fill_q != FW'(WIN)) fill_n = fill_q + FW'(1);
        end else begin
          col_n = col_q + CW'(1);
          st_n  = ST_RD;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      col_q  <= '0;
      fill_q <= '0;
    end else begin
      st_q   <= st_n;
      col_q  <= col_n;
      fill_q <= fill_n;
    end
  end

  assign st_o     = st_q;
  assign col_o    = col_q;
  assign sub_en_o = (fill_q == FW'(WIN));

  p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FW'(WIN));

  p_start_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start_i && !clr_i) |=> (st_q == ST_RD && col_q == '0));

  p_clr_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && clr_i) |=> (st_q == ST_CLR));

  p_col_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RD || st_q == ST_ADD || st_q == ST_SUB) |=> $stable(col_q));

  p_rearm_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CLR) |-> (fill_q == '0));

  p_col_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= CW'(COLS - 1));

endmodule

// File: rtl/sxc_lane.sv
module sxc_lane #(
  parameter int COLS = 6,
  parameter int SW   = 8,
  parameter int ACC  = 16,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  addr_i,
  input  logic           re_i,
  input  logic           we_i,
  input  logic           zero_i,
  input  logic           ld_add_i,
  input  logic           ld_sub_i,
  input  logic           sub_en_i,
  input  logic           bit_new_i,
  input  logic [SW-1:0]  samp_new_i,
  input  logic           bit_old_i,
  input  logic [SW-1:0]  samp_old_i,
  output logic [ACC-1:0] q_o
);

  logic [ACC-1:0] mem [COLS];
  logic [ACC-1:0] q_q;
  logic [ACC-1:0] work_q, work_n;
  logic [ACC-1:0] wdata;
  logic [ACC-1:0] new_ext, old_ext, add_term, old_term;
  logic [ACC:0]   sum_add, sum_sub;
  logic           work_en;

  assign new_ext  = {{(ACC-SW){samp_new_i[SW-1]}}, samp_new_i};
  assign old_ext  = {{(ACC-SW){samp_old_i[SW-1]}}, samp_old_i};
  assign add_term = bit_new_i ? new_ext : (~new_ext + ACC'(1));
  assign old_term = bit_old_i ? old_ext : (~old_ext + ACC'(1));
  assign sum_add  = {q_q[ACC-1], q_q} + {add_term[ACC-1], add_term};
  assign sum_sub  = {work_q[ACC-1], work_q} - {old_term[ACC-1], old_term};

  always_comb begin
    work_n = work_q;
    if (ld_add_i)                  work_n = sum_add[ACC-1:0];
    else if (ld_sub_i && sub_en_i) work_n = sum_sub[ACC-1:0];
  end

  assign work_en = ld_add_i | (ld_sub_i & sub_en_i);

  always_ff @(posedge clk) begin
    if (work_en) work_q <= work_n;
  end

  assign wdata = zero_i ? '0 : work_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata;
    if (re_i) q_q <= mem[addr_i];
  end

  assign q_o = q_q;

  p_no_overflow_add_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_add_i |-> (sum_add[ACC] == sum_add[ACC-1]));

  p_no_overflow_sub_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_sub_i && sub_en_i) |-> (sum_sub[ACC] == sum_sub[ACC-1]));

  p_sub_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_sub_i && !sub_en_i) |=> $stable(work_q));

endmodule

// File: rtl/sign_xcorr.sv
module sign_xcorr
  import sxc_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 6,
  parameter int WIN  = 3,
  parameter int SW   = 8,
  parameter int ACC  = 16,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               start_i,
  input  logic [ROWS-1:0]    bit_new_i,
  input  logic [COLS*SW-1:0] samp_new_i,
  input  logic [ROWS-1:0]    bit_old_i,
  input  logic [COLS*SW-1:0] samp_old_i,
  output logic               busy_o,
  input  logic               rd_req_i,
  input  logic [RW-1:0]      rd_row_i,
  input  logic [CW-1:0]      rd_col_i,
  output logic               rd_valid_o,
  output logic [ACC-1:0]     rd_data_o
);

  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  sxc_state_e    st;
  logic [CW-1:0] col;
  logic          sub_en;

  sxc_ctrl #(.COLS(COLS), .WIN(WIN)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_s2_q),
    .clr_i    (clr_i),
    .start_i  (start_i),
    .st_o     (st),
    .col_o    (col),
    .sub_en_o (sub_en)
  );

  logic idle, accept, rd_accept;
  assign idle      = (st == ST_IDLE);
  assign accept    = idle & start_i & ~clr_i;
  assign rd_accept = idle & rd_req_i & ~start_i & ~clr_i;
  assign busy_o    = ~idle;

  logic [ROWS-1:0]    bnew_q, bold_q;
  logic [COLS*SW-1:0] rnew_q, rold_q;

  always_ff @(posedge clk) begin
    if (accept) begin
      bnew_q <= bit_new_i;
      rnew_q <= samp_new_i;
      bold_q <= bit_old_i;
      rold_q <= samp_old_i;
    end
  end

  logic [SW-1:0] snew_col, sold_col;
  assign snew_col = rnew_q[col*SW +: SW];
  assign sold_col = rold_q[col*SW +: SW];

  logic [CW-1:0] lane_addr;
  logic          lane_re, lane_we;
  assign lane_addr = idle ? rd_col_i : col;
  assign lane_re   = (st == ST_RD) | rd_accept;
  assign lane_we   = (st == ST_CLR) | (st == ST_WR);

  logic [ACC-1:0] lane_q [ROWS];

  for (genvar gr = 0; gr < ROWS; gr++) begin : g_lane
    sxc_lane #(.COLS(COLS), .SW(SW), .ACC(ACC)) u_lane (
      .clk        (clk),
      .rst_n      (rst_s2_q),
      .addr_i     (lane_addr),
      .re_i       (lane_re),
      .we_i       (lane_we),
      .zero_i     (st == ST_CLR),
      .ld_add_i   (st == ST_ADD),
      .ld_sub_i   (st == ST_SUB),
      .sub_en_i   (sub_en),
      .bit_new_i  (bnew_q[gr]),
      .samp_new_i (snew_col),
      .bit_old_i  (bold_q[gr]),
      .samp_old_i (sold_col),
      .q_o        (lane_q[gr])
    );
  end

  logic          rd_valid_q;
  logic [RW-1:0] rd_row_q;

  always_ff @(posedge clk or negedge rst_s2_q) begin
    if (!rst_s2_q) rd_valid_q <= 1'b0;
    else           rd_valid_q <= rd_accept;
  end

  always_ff @(posedge clk) begin
    if (rd_accept) rd_row_q <= rd_row_i;
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = lane_q[rd_row_q];

  p_rd_busy_r9: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (rd_req_i && busy_o) |=> !rd_valid_o);

  p_cap_hold_r7: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (busy_o && $past(busy_o)) |-> ($stable(bnew_q) && $stable(rnew_q)
                                   && $stable(bold_q) && $stable(rold_q)));

  p_rd_cmd_r8: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (rd_req_i && (start_i || clr_i)) |=> !rd_valid_o);

endmodule

// File: tb/sign_xcorr_test.sv
module sign_xcorr_test;
  localparam int CLK_NS = 10;
  localparam int ROWS = 4;
  localparam int COLS = 6;
  localparam int WIN  = 3;
  localparam int SW   = 8;
  localparam int ACC  = 16;
  localparam int CW   = 3;
  localparam int RW   = 2;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               clr_i, start_i, rd_req_i;
  logic [ROWS-1:0]    bit_new_i, bit_old_i;
  logic [COLS*SW-1:0] samp_new_i, samp_old_i;
  logic [RW-1:0]      rd_row_i;
  logic [CW-1:0]      rd_col_i;
  logic               busy_o, rd_valid_o;
  logic [ACC-1:0]     rd_data_o;

  always #(CLK_NS/2) clk = ~clk;

  sign_xcorr #(.ROWS(ROWS), .COLS(COLS), .WIN(WIN), .SW(SW), .ACC(ACC)) uut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .start_i(start_i),
    .bit_new_i(bit_new_i), .samp_new_i(samp_new_i),
    .bit_old_i(bit_old_i), .samp_old_i(samp_old_i),
    .busy_o(busy_o), .rd_req_i(rd_req_i), .rd_row_i(rd_row_i),
    .rd_col_i(rd_col_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int exp_m [ROWS][COLS];
  int q_exp [$];
  string q_tag [$];
  logic [ROWS-1:0]    hist_b [WIN];
  logic [COLS*SW-1:0] hist_r [WIN];
  int h_idx, n_upd;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [COLS*SW-1:0] rand_samp();
    logic [COLS*SW-1:0] v;
    for (int c = 0; c < COLS; c++) v[c*SW +: SW] = SW'($urandom);
    return v;
  endfunction

  // Monitor: pops expected entries as read data appears.
  always @(negedge clk) begin
    if (rst_n && rd_valid_o) begin
      if (q_exp.size() == 0) begin
        check(1'b0, "R8 rd_valid without request", 1, 0);
      end else begin
        int e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check(int'($signed(rd_data_o)) == e, t, int'($signed(rd_data_o)), e);
      end
    end
  end

  task automatic read_all(input string tag);
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        @(negedge clk);
        rd_req_i = 1'b1;
        rd_row_i = RW'(r);
        rd_col_i = CW'(c);
        q_exp.push_back(exp_m[r][c]);
        q_tag.push_back(tag);
      end
    end
    @(negedge clk);
    rd_req_i = 1'b0;
    @(negedge clk);
    check(q_exp.size() == 0, "R8 every read answered", q_exp.size(), 0);
  endtask

  task automatic do_clear(input bit with_start, input string tag);
    int cnt;
    @(negedge clk);
    clr_i   = 1'b1;
    start_i = with_start;
    @(negedge clk);
    clr_i   = 1'b0;
    start_i = 1'b0;
    cnt = 0;
    while (busy_o && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == COLS, tag, cnt, COLS);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) exp_m[r][c] = 0;
    n_upd = 0;
    h_idx = 0;
  endtask

  task automatic do_update(input logic [ROWS-1:0] bn, input logic [COLS*SW-1:0] rn,
                           input bit disturb, input string tag);
    logic [ROWS-1:0]    bo;
    logic [COLS*SW-1:0] ro;
    int cnt;
    bit filled;
    filled = (n_upd >= WIN);
    if (filled) begin
      bo = hist_b[h_idx];
      ro = hist_r[h_idx];
    end else begin
      bo = ROWS'($urandom);
      ro = rand_samp();
    end
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        int s, so;
        s  = int'($signed(rn[c*SW +: SW]));
        so = int'($signed(ro[c*SW +: SW]));
        exp_m[r][c] += bn[r] ? s : -s;
        if (filled) exp_m[r][c] -= bo[r] ? so : -so;
      end
    end
    hist_b[h_idx] = bn;
    hist_r[h_idx] = rn;
    h_idx = (h_idx + 1) % WIN;
    n_upd++;

    @(negedge clk);
    bit_new_i  = bn;
    samp_new_i = rn;
    bit_old_i  = bo;
    samp_old_i = ro;
    start_i    = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cnt = 0;
    while (busy_o && cnt < 1000) begin
      if (disturb && cnt == 5) begin
        start_i    = 1'b1;
        clr_i      = 1'b1;
        rd_req_i   = 1'b1;
        bit_new_i  = ~bn;
        samp_new_i = ~rn;
        bit_old_i  = ~bo;
        samp_old_i = ~ro;
      end
      if (disturb && cnt == 6) begin
        check(rd_valid_o == 1'b0, "R9 read while busy", int'(rd_valid_o), 0);
        start_i  = 1'b0;
        clr_i    = 1'b0;
        rd_req_i = 1'b0;
      end
      cnt++;
      @(negedge clk);
    end
    check(cnt == 4*COLS, tag, cnt, 4*COLS);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    clr_i = 1'b0; start_i = 1'b0; rd_req_i = 1'b0;
    bit_new_i = '0; bit_old_i = '0; samp_new_i = '0; samp_old_i = '0;
    rd_row_i = '0; rd_col_i = '0;
    h_idx = 0; n_upd = 0;
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0, "R1 busy in reset", int'(busy_o), 0);
    check(rd_valid_o == 1'b0, "R1 rd_valid in reset", int'(rd_valid_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);
    check(rd_valid_o == 1'b0, "R1 rd_valid after reset", int'(rd_valid_o), 0);

    do_clear(1'b0, "R2 clear busy span");
    read_all("R2 cleared entry");

    for (int i = 0; i < WIN; i++) begin
      do_update(ROWS'($urandom), rand_samp(), 1'b0, "R5 busy span");
      read_all("R3/R4 filling-window entry");
    end
    for (int i = 0; i < 4; i++) begin
      do_update(ROWS'($urandom), rand_samp(), 1'b0, "R5 busy span");
      read_all("R4 full-window entry");
    end

    do_update('0, {COLS{8'h80}}, 1'b0, "R5 busy span");
    read_all("R11 most-negative sample entry");
    do_update('1, {COLS{8'h7f}}, 1'b0, "R5 busy span");
    read_all("R11 most-positive sample entry");

    do_update(ROWS'($urandom), rand_samp(), 1'b1, "R6 busy span with ignored commands");
    read_all("R7 operands sampled at start");

    do_clear(1'b1, "R10 clear wins busy span");
    check(busy_o == 1'b0, "R10 start dropped", int'(busy_o), 0);
    read_all("R10 cleared entry");

    for (int i = 0; i < WIN + 2; i++) begin
      do_update(ROWS'($urandom), rand_samp(), 1'b0, "R5 busy span");
      read_all("R12 re-armed window entry");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule